// File: doc/BRIEF.md
# Status Change Interrupt Latch

This block turns one status level, high while an equalizer is out of range, into an interrupt flag. The flag stays set until it is read, and an interrupt mask can hold it off. Software picks the trigger with a single select. The trigger is either every change of the status, or only its low-to-high step. A read strobe stands in for the host bus access to the flag register. Reading clears the flag unless a new event arrives in the same cycle.

The status input is already synchronous to the block clock. It is registered once. Edges are found by comparing that register with its previous value. After reset, the first registered sample is loaded into both the current-sample and previous-sample registers. That sample is the starting point and never counts as a change.

Top module: `status_irq_latch`

## Requirements
- R1: While reset is asserted, `flag_o`, `irq_o` and `status_o` are all 0.
- R2: `status_o` shows the value that `status_i` had at the previous rising clock edge.
- R3: A 0-to-1 step of the registered status sets `flag_o` when `mask_i` is 0, with either value of `edge_any_i`.
- R4: With `edge_any_i` = 1 (any change), a 1-to-0 step of the registered status sets `flag_o` when `mask_i` is 0.
- R5: With `edge_any_i` = 0 (rising only), a 1-to-0 step of the registered status leaves `flag_o` unchanged.
- R6: While `mask_i` = 1, no event sets `flag_o`. A change that was masked does not set the flag after the mask is removed.
- R7: Once set, `flag_o` stays 1 until a cycle with `rd_i` = 1. After that cycle it reads 0, provided no new event came in that cycle.
- R8: If a qualifying unmasked event and `rd_i` = 1 occur in the same cycle, `flag_o` is 1 afterwards.
- R9: `irq_o` is 1 exactly when `flag_o` is 1 and `mask_i` is 0. Setting the mask hides the request but keeps the flag.
- R10: The first registered sample after reset creates no event, even when `status_i` is 1 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 1 | Out-of-range status level, synchronous |
| edge_any_i | input | 1 | 1: any change triggers, 0: only a rising step triggers |
| mask_i | input | 1 | 1: the interrupt is masked |
| rd_i | input | 1 | One-cycle strobe that reads, and so clears, the flag |
| flag_o | output | 1 | Sticky interrupt flag |
| status_o | output | 1 | Registered status level |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
`status_o` is due one rising edge after `status_i` is applied. A status step reaches `flag_o` one edge later still, because the edge is found between the two sample registers. `rd_i` and `mask_i` act at the edge on which they are held, so their effect on `flag_o` is due one edge after they are applied. `irq_o` follows `mask_i` and `flag_o` without any extra edge. The bench drives every input on a falling edge and reads the results on the next falling edge. Each vector's expected flag is therefore worked out from the status of the two vectors before it.

// File: rtl/sil_pkg.sv
package sil_pkg;

   typedef enum logic {
      SIL_RISE_ONLY  = 1'b0,
      SIL_ANY_CHANGE = 1'b1
   } sil_trig_e;

   typedef struct packed {
      logic primed;
      logic prev;
      logic cur;
   } sil_sample_t;

endpackage

// File: rtl/sil_sampler.sv
module sil_sampler
   import sil_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        status_i,
   output sil_sample_t smp_o
);

   sil_sample_t smp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         smp_q <= '0;
      end else if (!smp_q.primed) begin
         // first sample after reset seeds both stages: no change seen
         smp_q.cur    <= status_i;
         smp_q.prev   <= status_i;
         smp_q.primed <= 1'b1;
      end else begin
         smp_q.prev <= smp_q.cur;
         smp_q.cur  <= status_i;
      end
   end

   assign smp_o = smp_q;

endmodule

// File: rtl/sil_edge_det.sv
module sil_edge_det
   import sil_pkg::*;
(
   input  sil_sample_t smp_i,
   input  sil_trig_e   trig_i,
   output logic        evt_o
);

   logic rise, fall;

   always_comb begin
      rise  = smp_i.cur & ~smp_i.prev;
      fall  = ~smp_i.cur & smp_i.prev;
      evt_o = 1'b0;
      if (smp_i.primed) begin
         unique case (trig_i)
            SIL_ANY_CHANGE: evt_o = rise | fall;
            default:        evt_o = rise;
         endcase
      end
   end

endmodule

// File: rtl/sil_flag.sv
module sil_flag #(
   parameter bit FLAG_SET_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic rd_i,
   output logic flag_o
);

   logic flag_q, flag_d;

   generate
      if (FLAG_SET_WINS) begin : g_set_wins
         always_comb flag_d = set_i | (flag_q & ~rd_i);
      end else begin : g_read_wins
         always_comb flag_d = rd_i ? 1'b0 : (flag_q | set_i);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/status_irq_latch.sv
module status_irq_latch
   import sil_pkg::*;
#(
   parameter int unsigned FLAG_SET_WINS = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic status_i,
   input  logic edge_any_i,
   input  logic mask_i,
   input  logic rd_i,
   output logic flag_o,
   output logic status_o,
   output logic irq_o
);

   localparam bit SetWins = (FLAG_SET_WINS != 0);

   generate
      if (FLAG_SET_WINS > 1) begin : g_bad_param
         $error("FLAG_SET_WINS must be 0 or 1");
      end
   endgenerate

   sil_sample_t smp;
   sil_trig_e   trig;
   logic        evt;
   logic        primed;
   logic        set;

   assign trig   = sil_trig_e'(edge_any_i);
   assign primed = smp.primed;

   sil_sampler u_sampler (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .status_i (status_i),
      .smp_o    (smp)
   );

   sil_edge_det u_edge (
      .smp_i  (smp),
      .trig_i (trig),
      .evt_o  (evt)
   );

   assign set = evt & ~mask_i;

   sil_flag #(.FLAG_SET_WINS(SetWins)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set),
      .rd_i   (rd_i),
      .flag_o (flag_o)
   );

   assign status_o = smp.cur;
   assign irq_o    = flag_o & ~mask_i;

endmodule

// File: rtl/sil_checker.sv
module sil_checker #(
   parameter int unsigned FLAG_SET_WINS = 1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic status_i,
   input logic edge_any_i,
   input logic mask_i,
   input logic rd_i,
   input logic flag_o,
   input logic status_o,
   input logic irq_o,
   input logic evt_i,
   input logic primed_i
);

   assert_status_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_i |-> (status_o == $past(status_i)));

   assert_rise_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mask_i && $past(primed_i) && $rose(status_o)) |=> flag_o);

   assert_fall_any_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_any_i && !mask_i && $past(primed_i) && $fell(status_o)) |=> flag_o);

   assert_fall_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_any_i && !flag_o && $fell(status_o)) |=> !flag_o);

   assert_mask_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_i && !flag_o) |=> !flag_o);

   assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !evt_i) |=> !flag_o);

   assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !rd_i) |=> flag_o);

   generate
      if (FLAG_SET_WINS != 0) begin : g_set_wins_chk
         assert_event_beats_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_i && evt_i && !mask_i) |=> flag_o);
      end
   endgenerate

   assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_i |-> !irq_o);

   assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> flag_o);

   assert_no_first_event_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !primed_i |=> !flag_o);

endmodule

bind status_irq_latch sil_checker #(.FLAG_SET_WINS(FLAG_SET_WINS)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .status_i   (status_i),
   .edge_any_i (edge_any_i),
   .mask_i     (mask_i),
   .rd_i       (rd_i),
   .flag_o     (flag_o),
   .status_o   (status_o),
   .irq_o      (irq_o),
   .evt_i      (evt),
   .primed_i   (primed)
);

// File: tb/status_irq_latch_tb_top.sv
`timescale 1ns/1ps
module status_irq_latch_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   logic status, edge_any, mask, rd;
   logic flag, stat_o, irq;
   int   n_chk = 0;
   int   n_err = 0;

   always #10 clk = ~clk;

   status_irq_latch dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .status_i   (status),
      .edge_any_i (edge_any),
      .mask_i     (mask),
      .rd_i       (rd),
      .flag_o     (flag),
      .status_o   (stat_o),
      .irq_o      (irq)
   );

   // bits: {status, edge_any, mask, rd, exp_flag, exp_irq}; exp_status = status
   localparam int NV = 18;
   localparam logic [5:0] VEC [NV] = '{
      6'b0_1_0_0_0_0,  // prime sample (R10)
      6'b1_0_0_0_0_0,
      6'b1_0_0_0_1_1,  // rising, rise-only mode (R3)
      6'b1_0_0_0_1_1,  // holds (R7)
      6'b1_0_0_1_0_0,  // read clears (R7)
      6'b0_0_0_0_0_0,
      6'b0_0_0_0_0_0,  // fall ignored in rise-only (R5)
      6'b1_1_0_0_0_0,
      6'b1_1_0_0_1_1,  // rising, any mode (R3)
      6'b0_1_0_1_0_0,  // read (R7)
      6'b0_1_0_0_1_1,  // fall, any mode (R4)
      6'b0_1_1_0_1_0,  // mask hides irq, flag kept (R9)
      6'b1_1_0_1_0_0,  // read (R7)
      6'b1_1_1_0_0_0,  // masked rise (R6)
      6'b0_1_0_0_0_0,  // not retroactive (R6)
      6'b0_1_0_1_1_1,  // event with read (R8)
      6'b0_1_0_0_1_1,
      6'b0_1_0_1_0_0
   };

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s got %0b exp %0b", req, what, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; status = 1'b0; edge_any = 1'b0; mask = 1'b0; rd = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "flag in reset", flag, 1'b0);
      chk("R1", "irq in reset", irq, 1'b0);
      chk("R1", "status in reset", stat_o, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         {status, edge_any, mask, rd} = VEC[i][5:2];
         @(negedge clk);
         chk("R2", $sformatf("vec %0d status", i), stat_o, VEC[i][5]);
         chk("R3-R8", $sformatf("vec %0d flag", i), flag, VEC[i][1]);
         chk("R9", $sformatf("vec %0d irq", i), irq, VEC[i][0]);
      end

      // set the flag, then an asynchronous reset clears everything (R1)
      status = 1'b1; edge_any = 1'b1; mask = 1'b0; rd = 1'b0;
      repeat (2) @(negedge clk);
      chk("R3", "flag before reset", flag, 1'b1);
      rst_n = 1'b0;
      #2;
      chk("R1", "flag after async reset", flag, 1'b0);
      chk("R1", "irq after async reset", irq, 1'b0);
      chk("R1", "status after async reset", stat_o, 1'b0);

      // release with the status already high: no event (R10)
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10", "flag after release with status high", flag, 1'b0);
      chk("R10", "irq after release with status high", irq, 1'b0);
      chk("R2", "status after release", stat_o, 1'b1);

      // falling step in rise-only mode after release (R5)
      edge_any = 1'b0; status = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5", "fall in rise-only after release", flag, 1'b0);
      chk("R2", "status low", stat_o, 1'b0);

      finish_run();
   end

endmodule